// File: doc/BRIEF.md
# Display Pipeline Bring-Up Sequencer

This controller powers up a three-stage video path made of a layer compositor, a timing generator and an output encoder. A single `go` pulse starts an attempt. The attempt first pulses a clear to the write-one-to-clear FIFO error flags. It then switches the three stages off, starting at the output side and working back towards the compositor. Next it raises a configuration request and waits for software or a companion engine to report that the stage registers are written. It then sends a register-load strobe to the compositor and switches the stages back on, starting at the compositor. After each switch-on it waits one frame plus a guard margin.

After the last wait, the sequencer samples the encoder FIFO underflow and overflow flags. If either flag is set, the attempt is repeated from the clear step. A clean attempt ends in a held `done` state. After a bounded number of repeated attempts, a persistent error ends in a `fail` state with every stage switched off.

The frame wait, in microsecond ticks, is `US_PER_SEC / rate + MARGIN_US`, computed by a serial divider from the refresh rate captured at `go`. A build-time option instead treats the input as a ready-made frame period in microseconds.

Top module: `disp_bringup_seq`

## Requirements
- R1: While reset is held, and in the idle state after it, every output is low.
- R2: Each attempt begins with a one-cycle `fifo_clr_o` pulse. In the following cycles the stages are switched off one per cycle: `enc_en_o` drops first, then `tc_en_o` on the next cycle, then `cmp_start_o` on the cycle after that.
- R3: After the switch-off steps, `cfg_req_o` stays high and no load strobe is issued until `cfg_done_i` is seen high.
- R4: `cmp_load_o` is a single-cycle pulse, and `cmp_start_o` rises on the cycle right after it.
- R5: Stages are switched on in the order `cmp_start_o`, then `tc_en_o`, then `enc_en_o`. A stage never rises while the stage after it is high, nor while the stage before it is low.
- R6: Each of the three waits lasts exactly W cycles in which `us_tick_i` is high. In rate mode, W = US_PER_SEC / max(rate,1) + MARGIN_US, using integer division. The rate is sampled only on the cycle that `go_i` is accepted. The flags are checked on the cycle after the third wait ends, so `done_o` rises W+1 cycles after `enc_en_o` when the tick is always high.
- R7: With RATE_IS_PERIOD set, `frame_param_i` is taken as the frame period in microseconds, and W = period + MARGIN_US.
- R8: If `fifo_uflow_i` or `fifo_oflow_i` is high in the check cycle, a new attempt starts: a fresh clear pulse, the switch-off steps and another load strobe.
- R9: At most MAX_RETRY repeated attempts follow the first one. If the last of them also sees an error, `fail_o` is raised and held, with all three enables and `done_o` low.
- R10: After a clean check, `done_o` stays high with all three enables high until the next accepted `go_i`. `go_i` is also accepted from the fail state.
- R11: `go_i` pulses that arrive while an attempt is running are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| go_i | input | 1 | Start command, accepted in idle, done or fail |
| frame_param_i | input | PARAM_W | Refresh rate in Hz, or frame period in µs when RATE_IS_PERIOD |
| us_tick_i | input | 1 | One-cycle microsecond strobe |
| cfg_done_i | input | 1 | Stage registers written |
| fifo_uflow_i | input | 1 | Encoder FIFO underflow flag |
| fifo_oflow_i | input | 1 | Encoder FIFO overflow flag |
| fifo_clr_o | output | 1 | Clear pulse for the FIFO error flags |
| cfg_req_o | output | 1 | Stage configuration requested |
| cmp_load_o | output | 1 | Compositor register-load strobe |
| cmp_start_o | output | 1 | Compositor start |
| tc_en_o | output | 1 | Timing generator enable |
| enc_en_o | output | 1 | Output encoder video enable |
| done_o | output | 1 | Pipeline running cleanly |
| fail_o | output | 1 | Retry budget exhausted |

## Verification
The bench targets the retry boundary. With exactly MAX_RETRY bad attempts the run must still succeed, and with one more it must fail. An off-by-one retry counter would turn the first into a failure or allow a fifth load strobe. Wait lengths are measured in ticks, both with a sparse tick and with a zero rate. A timer that counts cycles instead of ticks, or a divider that does not clamp a zero divisor, would report the wrong length. The bench also checks the one-per-cycle switch-off pattern on every restart, a held configuration handshake, a rate changed just after `go`, and a `go` that arrives mid-sequence. A design that mixes up the switch-off order, loads before `cfg_done_i`, resamples the rate, or restarts on a busy `go` would show up as a wrong enable pattern, a wrong wait length or an extra attempt.

// File: rtl/dps_pkg.sv
package dps_pkg;

   typedef enum logic [3:0] {
      S_IDLE,
      S_DIS_ENC,
      S_DIS_TC,
      S_DIS_CMP,
      S_CFG,
      S_LOAD,
      S_W1,
      S_W2,
      S_W3,
      S_CHK,
      S_DONE,
      S_FAIL
   } seq_state_e;

endpackage

// File: rtl/dps_recip_div.sv
// Serial restoring divider: constant numerator over a run-time divisor.
// One quotient bit per cycle; a zero divisor is treated as one.
module dps_recip_div #(
   parameter int NUM_W = 21,
   parameter int DEN_W = 8,
   parameter int NUM   = 1000000
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [DEN_W-1:0] den_i,
   output logic [NUM_W-1:0] quo_o,
   output logic             valid_o
);
   localparam int CNT_W = $clog2(NUM_W + 1);

   logic [NUM_W-1:0] num_sh_q, quo_q;
   logic [DEN_W:0]   rem_q;
   logic [DEN_W-1:0] den_q;
   logic [CNT_W-1:0] left_q;
   logic             busy_q, valid_q;
   logic [DEN_W:0]   trial;
   logic             fits;

   assign trial = (rem_q << 1) | {{DEN_W{1'b0}}, num_sh_q[NUM_W-1]};
   assign fits  = trial >= {1'b0, den_q};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         num_sh_q <= '0;
         quo_q    <= '0;
         rem_q    <= '0;
         den_q    <= DEN_W'(1);
         left_q   <= '0;
         busy_q   <= 1'b0;
         valid_q  <= 1'b0;
      end else if (start_i) begin
         num_sh_q <= NUM_W'(NUM);
         quo_q    <= '0;
         rem_q    <= '0;
         den_q    <= (den_i == '0) ? DEN_W'(1) : den_i;
         left_q   <= CNT_W'(NUM_W);
         busy_q   <= 1'b1;
         valid_q  <= 1'b0;
      end else if (busy_q) begin
         num_sh_q <= num_sh_q << 1;
         quo_q    <= {quo_q[NUM_W-2:0], fits};
         rem_q    <= fits ? (trial - {1'b0, den_q}) : trial;
         left_q   <= left_q - 1'b1;
         if (left_q == CNT_W'(1)) begin
            busy_q  <= 1'b0;
            valid_q <= 1'b1;
         end
      end
   end

   assign quo_o   = quo_q;
   assign valid_o = valid_q;

   // R6: partial remainder stays below the divisor during the run
   a_r6_rem_below_div: assert property (@(posedge clk) disable iff (!rst_n)
      busy_q |-> (rem_q < {1'b0, den_q}));

   // R6: a finished result stays valid until the next start
   a_r6_result_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (valid_q && !start_i) |=> valid_q);

endmodule

// File: rtl/dps_frame_period.sv
// Frame wait length in microsecond ticks, captured at start.
module dps_frame_period #(
   parameter int PARAM_W        = 8,
   parameter int WAIT_W         = 21,
   parameter int US_PER_SEC     = 1000000,
   parameter int MARGIN_US      = 500,
   parameter bit RATE_IS_PERIOD = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start_i,
   input  logic [PARAM_W-1:0] param_i,
   output logic [WAIT_W-1:0]  period_o,
   output logic               valid_o
);
   localparam logic [WAIT_W-1:0] MARGIN = WAIT_W'(MARGIN_US);

   generate
      if (RATE_IS_PERIOD) begin : g_direct
         logic [WAIT_W-1:0] per_q;
         logic              val_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               per_q <= '0;
               val_q <= 1'b0;
            end else if (start_i) begin
               per_q <= WAIT_W'(param_i) + MARGIN;
               val_q <= 1'b1;
            end
         end
         assign period_o = per_q;
         assign valid_o  = val_q;
      end else begin : g_rate
         logic [WAIT_W-1:0] quo;
         logic              qv;
         dps_recip_div #(
            .NUM_W (WAIT_W),
            .DEN_W (PARAM_W),
            .NUM   (US_PER_SEC)
         ) i_div (
            .clk     (clk),
            .rst_n   (rst_n),
            .start_i (start_i),
            .den_i   (param_i),
            .quo_o   (quo),
            .valid_o (qv)
         );
         assign period_o = quo + MARGIN;
         assign valid_o  = qv;
      end
   endgenerate

endmodule

// File: rtl/dps_wait_timer.sv
// Down-counter of microsecond ticks; expire_o marks the last tick of a wait.
module dps_wait_timer #(
   parameter int W = 21
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load_i,
   input  logic [W-1:0] len_i,
   input  logic         tick_i,
   output logic         expire_o
);
   logic [W-1:0] cnt_q;
   logic         run_q;

   assign expire_o = run_q && tick_i && (cnt_q == W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         run_q <= 1'b0;
      end else if (load_i) begin
         cnt_q <= len_i;
         run_q <= 1'b1;
      end else if (run_q && tick_i) begin
         cnt_q <= cnt_q - 1'b1;
         if (cnt_q == W'(1)) run_q <= 1'b0;
      end
   end

   // R6: a wait is never armed with a zero length
   a_r6_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      load_i |-> (len_i != '0));

   // R6: the count only moves on a tick
   a_r6_tick_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && !tick_i && !load_i) |=> $stable(cnt_q));

endmodule

// File: rtl/disp_bringup_seq.sv
module disp_bringup_seq
   import dps_pkg::*;
#(
   parameter int WAIT_W         = 21,
   parameter int PARAM_W        = 8,
   parameter int US_PER_SEC     = 1000000,
   parameter int MARGIN_US      = 500,
   parameter int MAX_RETRY      = 3,
   parameter bit RATE_IS_PERIOD = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               go_i,
   input  logic [PARAM_W-1:0] frame_param_i,
   input  logic               us_tick_i,
   input  logic               cfg_done_i,
   input  logic               fifo_uflow_i,
   input  logic               fifo_oflow_i,
   output logic               fifo_clr_o,
   output logic               cfg_req_o,
   output logic               cmp_load_o,
   output logic               cmp_start_o,
   output logic               tc_en_o,
   output logic               enc_en_o,
   output logic               done_o,
   output logic               fail_o
);
   localparam int RETRY_W = (MAX_RETRY < 1) ? 1 : $clog2(MAX_RETRY + 1);
   localparam logic [RETRY_W-1:0] RETRY_LAST = RETRY_W'(MAX_RETRY);

   generate
      if (MARGIN_US < 1) begin : g_bad_margin
         $error("MARGIN_US must be at least 1");
      end
      if (PARAM_W > WAIT_W) begin : g_bad_param_w
         $error("PARAM_W must not exceed WAIT_W");
      end
      if (MAX_RETRY < 0) begin : g_bad_retry
         $error("MAX_RETRY must not be negative");
      end
      if (!RATE_IS_PERIOD && (longint'(US_PER_SEC) + MARGIN_US >= (longint'(1) << WAIT_W))) begin : g_bad_rate_w
         $error("WAIT_W too narrow for one second plus margin");
      end
      if (RATE_IS_PERIOD && ((longint'(1) << PARAM_W) - 1 + MARGIN_US >= (longint'(1) << WAIT_W))) begin : g_bad_per_w
         $error("WAIT_W too narrow for the largest period plus margin");
      end
   endgenerate

   seq_state_e          state_q, state_d;
   logic                cmp_q, tc_q, enc_q;
   logic [RETRY_W-1:0]  retry_q;
   logic                go_ok, fifo_err;
   logic [WAIT_W-1:0]   period;
   logic                per_valid;
   logic                tmr_load, tmr_exp;

   assign go_ok    = go_i && (state_q == S_IDLE || state_q == S_DONE || state_q == S_FAIL);
   assign fifo_err = fifo_uflow_i || fifo_oflow_i;

   dps_frame_period #(
      .PARAM_W        (PARAM_W),
      .WAIT_W         (WAIT_W),
      .US_PER_SEC     (US_PER_SEC),
      .MARGIN_US      (MARGIN_US),
      .RATE_IS_PERIOD (RATE_IS_PERIOD)
   ) i_period (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (go_ok),
      .param_i  (frame_param_i),
      .period_o (period),
      .valid_o  (per_valid)
   );

   assign tmr_load = (state_q == S_LOAD) ||
                     ((state_q == S_W1 || state_q == S_W2) && tmr_exp);

   dps_wait_timer #(.W(WAIT_W)) i_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load_i   (tmr_load),
      .len_i    (period),
      .tick_i   (us_tick_i),
      .expire_o (tmr_exp)
   );

   always_comb begin
      state_d = state_q;
      case (state_q)
         S_IDLE, S_DONE, S_FAIL: if (go_i) state_d = S_DIS_ENC;
         S_DIS_ENC: state_d = S_DIS_TC;
         S_DIS_TC:  state_d = S_DIS_CMP;
         S_DIS_CMP: state_d = S_CFG;
         S_CFG:     if (cfg_done_i && per_valid) state_d = S_LOAD;
         S_LOAD:    state_d = S_W1;
         S_W1:      if (tmr_exp) state_d = S_W2;
         S_W2:      if (tmr_exp) state_d = S_W3;
         S_W3:      if (tmr_exp) state_d = S_CHK;
         S_CHK: begin
            if (!fifo_err)                state_d = S_DONE;
            else if (retry_q == RETRY_LAST) state_d = S_FAIL;
            else                          state_d = S_DIS_ENC;
         end
         default:   state_d = S_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= S_IDLE;
         cmp_q   <= 1'b0;
         tc_q    <= 1'b0;
         enc_q   <= 1'b0;
         retry_q <= '0;
      end else begin
         state_q <= state_d;
         case (state_q)
            S_IDLE, S_DONE, S_FAIL: if (go_i) retry_q <= '0;
            S_DIS_ENC: enc_q <= 1'b0;
            S_DIS_TC:  tc_q  <= 1'b0;
            S_DIS_CMP: cmp_q <= 1'b0;
            S_LOAD:    cmp_q <= 1'b1;
            S_W1:      if (tmr_exp) tc_q  <= 1'b1;
            S_W2:      if (tmr_exp) enc_q <= 1'b1;
            S_CHK: begin
               if (fifo_err) begin
                  if (retry_q == RETRY_LAST) begin
                     cmp_q <= 1'b0;
                     tc_q  <= 1'b0;
                     enc_q <= 1'b0;
                  end else begin
                     retry_q <= retry_q + 1'b1;
                  end
               end
            end
            default: ;
         endcase
      end
   end

   assign fifo_clr_o  = (state_q == S_DIS_ENC);
   assign cfg_req_o   = (state_q == S_CFG);
   assign cmp_load_o  = (state_q == S_LOAD);
   assign cmp_start_o = cmp_q;
   assign tc_en_o     = tc_q;
   assign enc_en_o    = enc_q;
   assign done_o      = (state_q == S_DONE);
   assign fail_o      = (state_q == S_FAIL);

   // R2: the clear is one cycle wide and the encoder drops right after it
   a_r2_clr_single: assert property (@(posedge clk) disable iff (!rst_n)
      fifo_clr_o |=> (!fifo_clr_o && !enc_en_o));

   // R2: the compositor never drops while a later stage is still on
   a_r2_cmp_drops_last: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(cmp_start_o) |-> (!tc_en_o && !enc_en_o));

   // R3: load only after a configuration handshake
   a_r3_load_after_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_load_o |-> $past(cfg_req_o && cfg_done_i));

   // R4: start follows the load strobe on the next cycle
   a_r4_start_after_load: assert property (@(posedge clk) disable iff (!rst_n)
      cmp_load_o |=> (cmp_start_o && !cmp_load_o));

   // R5: switch-on order
   a_r5_tc_after_cmp: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tc_en_o) |-> (cmp_start_o && !enc_en_o));
   a_r5_enc_after_tc: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(enc_en_o) |-> tc_en_o);

   // R9: fail leaves every stage off, and the attempt count stays in budget
   a_r9_fail_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      fail_o |-> (!cmp_start_o && !tc_en_o && !enc_en_o && !done_o));
   a_r9_retry_bound: assert property (@(posedge clk) disable iff (!rst_n)
      retry_q <= RETRY_LAST);

   // R10: done holds with all stages on until a new go
   a_r10_done_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (done_o && !go_i) |=> (done_o && cmp_start_o && tc_en_o && enc_en_o));

   // R11: a go during configuration does not restart the attempt
   a_r11_busy_go: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_req_o && go_i) |=> !fifo_clr_o);

endmodule

// File: tb/test_disp_bringup_seq.sv
module test_disp_bringup_seq;
   localparam int WAIT_W  = 21;
   localparam int PARAM_W = 8;
   localparam int US      = 1000;
   localparam int MARG    = 5;
   localparam int RETRY   = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   always #2 clk = ~clk;

   logic go = 1'b0;
   logic [PARAM_W-1:0] fparam = '0;
   logic tick = 1'b0, cfg_done = 1'b0, uf = 1'b0, of = 1'b0;
   logic fifo_clr, cfg_req, load, cmp, tc, enc, done, fail;

   logic go2 = 1'b0;
   logic [PARAM_W-1:0] fparam2 = '0;
   logic cfg_done2 = 1'b0;
   logic clr2, req2, load2, cmp2, tc2, enc2, done2, fail2;

   int n_cmp = 0, n_bad = 0;
   int tick_every = 1, tph = 0;
   int attempt = 0, bad_n = 0;
   bit bad_of = 1'b0;
   int cfg_delay = 2, cfg_cnt = 0;
   int cyc = 0, n_load = 0, n_clr = 0, n_dis = 0;
   int tcnt = 0, tcnt2 = 0, w1 = -1, w2 = -1, e_cyc = 0, lat = -1, dstep = 0;
   logic p_cmp = 0, p_tc = 0, p_enc = 0, p_done = 0, p_load = 0;
   int c2_cmp = 0, c2_tc = -1;
   logic p2_cmp = 0, p2_tc = 0;

   disp_bringup_seq #(
      .WAIT_W(WAIT_W), .PARAM_W(PARAM_W), .US_PER_SEC(US), .MARGIN_US(MARG),
      .MAX_RETRY(RETRY), .RATE_IS_PERIOD(1'b0)
   ) i_disp_bringup_seq (
      .clk(clk), .rst_n(rst_n), .go_i(go), .frame_param_i(fparam), .us_tick_i(tick),
      .cfg_done_i(cfg_done), .fifo_uflow_i(uf), .fifo_oflow_i(of),
      .fifo_clr_o(fifo_clr), .cfg_req_o(cfg_req), .cmp_load_o(load), .cmp_start_o(cmp),
      .tc_en_o(tc), .enc_en_o(enc), .done_o(done), .fail_o(fail)
   );

   disp_bringup_seq #(
      .WAIT_W(WAIT_W), .PARAM_W(PARAM_W), .US_PER_SEC(US), .MARGIN_US(MARG),
      .MAX_RETRY(RETRY), .RATE_IS_PERIOD(1'b1)
   ) i_disp_bringup_seq_per (
      .clk(clk), .rst_n(rst_n), .go_i(go2), .frame_param_i(fparam2), .us_tick_i(tick),
      .cfg_done_i(cfg_done2), .fifo_uflow_i(uf), .fifo_oflow_i(of),
      .fifo_clr_o(clr2), .cfg_req_o(req2), .cmp_load_o(load2), .cmp_start_o(cmp2),
      .tc_en_o(tc2), .enc_en_o(enc2), .done_o(done2), .fail_o(fail2)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int wlen(input int rate);
      return US / ((rate == 0) ? 1 : rate) + MARG;
   endfunction

   // input drivers, one time unit after the rising edge
   initial forever begin
      @(posedge clk); #1;
      tph++;
      if (tph >= tick_every) begin tph = 0; tick = 1'b1; end
      else tick = 1'b0;
      if (fifo_clr) begin
         attempt++;
         uf = (attempt <= bad_n) && !bad_of;
         of = (attempt <= bad_n) && bad_of;
      end
      if (cfg_req) begin
         if (cfg_cnt >= cfg_delay) cfg_done = 1'b1;
         cfg_cnt++;
      end else begin
         cfg_done = 1'b0;
         cfg_cnt  = 0;
      end
      cfg_done2 = req2;
   end

   // output monitor, on the falling edge
   initial forever begin
      @(negedge clk);
      cyc++;
      if (load) n_load++;
      if (fifo_clr) n_clr++;
      if (cmp && !p_cmp) begin
         chk(p_load, "R4 start follows load", int'(p_load), 1);
         tcnt = int'(tick);
      end else if (cmp && !tc && !enc) tcnt += int'(tick);
      if (tc && !p_tc) begin
         chk(cmp && !enc, "R5 timing enable after compositor only", int'({cmp, enc}), 2);
         w1 = tcnt;
         tcnt2 = int'(tick);
      end else if (tc && !enc) tcnt2 += int'(tick);
      if (enc && !p_enc) begin
         chk(tc, "R5 encoder enable after timing enable", int'(tc), 1);
         w2 = tcnt2;
         e_cyc = cyc;
      end
      if (done && !p_done) lat = cyc - e_cyc;
      if (dstep > 0) begin
         case (dstep)
            1: chk({cmp, tc, enc} == 3'b110, "R2 encoder off first", int'({cmp, tc, enc}), 6);
            2: chk({cmp, tc, enc} == 3'b100, "R2 timing off second", int'({cmp, tc, enc}), 4);
            default: chk({cmp, tc, enc} == 3'b000, "R2 compositor off last", int'({cmp, tc, enc}), 0);
         endcase
         dstep = (dstep == 3) ? 0 : dstep + 1;
      end
      if (fifo_clr && cmp && tc && enc) begin
         dstep = 1;
         n_dis++;
      end
      p_cmp = cmp; p_tc = tc; p_enc = enc; p_done = done; p_load = load;
      if (cmp2 && !p2_cmp) c2_cmp = cyc;
      if (tc2 && !p2_tc) c2_tc = cyc;
      p2_cmp = cmp2; p2_tc = tc2;
   end

   task automatic clr_stats();
      attempt = 0; n_load = 0; n_clr = 0; n_dis = 0; w1 = -1; w2 = -1; lat = -1;
   endtask

   task automatic pulse_go();
      @(negedge clk); go = 1'b1;
      @(negedge clk); go = 1'b0;
   endtask

   task automatic run(input int rate, input int alt, input int every, input int bad, input bit use_of);
      fparam = PARAM_W'(rate);
      tick_every = every;
      bad_n = bad;
      bad_of = use_of;
      clr_stats();
      pulse_go();
      fparam = PARAM_W'(alt);
      while (!(done || fail)) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic summary();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual 1 expected 0");
      summary();
   end

   initial begin
      // R1: reset and idle state
      repeat (4) @(negedge clk);
      chk({fifo_clr, cfg_req, load, cmp, tc, enc, done, fail} == 8'h00, "R1 outputs low in reset",
          int'({fifo_clr, cfg_req, load, cmp, tc, enc, done, fail}), 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      chk({fifo_clr, cfg_req, load, cmp, tc, enc, done, fail} == 8'h00, "R1 outputs low in idle",
          int'({fifo_clr, cfg_req, load, cmp, tc, enc, done, fail}), 0);

      // clean run, tick every cycle
      run(60, 60, 1, 0, 1'b0);
      chk(done && !fail, "R10 clean run ends done", int'(done), 1);
      chk(w1 == wlen(60), "R6 first wait length", w1, wlen(60));
      chk(w2 == wlen(60), "R6 second wait length", w2, wlen(60));
      chk(lat == wlen(60) + 1, "R6 third wait and check cycle", lat, wlen(60) + 1);
      chk(n_load == 1, "R4 single load strobe", n_load, 1);
      chk(n_clr == 1, "R2 single clear pulse", n_clr, 1);
      repeat (20) @(negedge clk);
      chk(done && cmp && tc && enc, "R10 done held with all enables", int'({done, cmp, tc, enc}), 15);

      // two bad attempts, sparse tick, rate changed right after go
      run(50, 7, 3, 2, 1'b0);
      chk(done, "R8 recovers after underflow", int'(done), 1);
      chk(n_load == 3, "R8 attempts after two underflows", n_load, 3);
      chk(n_clr == 3, "R8 clear pulse per attempt", n_clr, 3);
      chk(n_dis == 3, "R2 switch-off sequences seen", n_dis, 3);
      chk(w1 == wlen(50), "R6 wait counts ticks, rate latched at go", w1, wlen(50));
      chk(w2 == wlen(50), "R6 second wait with sparse tick", w2, wlen(50));

      // retry boundary: MAX_RETRY bad attempts still succeed
      run(200, 200, 1, RETRY, 1'b1);
      chk(done && !fail, "R9 last retry succeeds", int'(done), 1);
      chk(n_load == RETRY + 1, "R9 attempts at the boundary", n_load, RETRY + 1);
      chk(w1 == wlen(200), "R6 wait at rate 200", w1, wlen(200));

      // one more bad attempt: fail
      run(100, 100, 2, RETRY + 1, 1'b0);
      chk(fail && !done, "R9 exhausted budget fails", int'(fail), 1);
      chk(n_load == RETRY + 1, "R9 no attempt past the budget", n_load, RETRY + 1);
      repeat (10) @(negedge clk);
      chk(fail && !cmp && !tc && !enc, "R9 fail holds, stages off", int'({fail, cmp, tc, enc}), 8);

      // go from fail; zero rate clamps to one
      run(0, 0, 1, 0, 1'b0);
      chk(done, "R10 go accepted from fail", int'(done), 1);
      chk(w1 == wlen(0), "R6 zero rate clamped", w1, wlen(0));

      // configuration handshake held off
      cfg_delay = 60;
      tick_every = 1; bad_n = 0; fparam = PARAM_W'(60);
      clr_stats();
      pulse_go();
      while (!cfg_req) @(negedge clk);
      repeat (50) @(negedge clk);
      chk(n_load == 0, "R3 no load before cfg_done", n_load, 0);
      chk(cfg_req, "R3 request held while waiting", int'(cfg_req), 1);
      while (!done) @(negedge clk);
      chk(n_load == 1, "R3 load after cfg_done", n_load, 1);
      cfg_delay = 2;

      // go while busy is ignored
      clr_stats();
      pulse_go();
      while (!tc) @(negedge clk);
      pulse_go();
      while (!done) @(negedge clk);
      @(negedge clk);
      chk(n_clr == 1, "R11 busy go starts no attempt", n_clr, 1);
      chk(w2 == wlen(60), "R11 busy go leaves wait intact", w2, wlen(60));

      // period-input variant
      fparam2 = PARAM_W'(30);
      tick_every = 1;
      @(negedge clk); go2 = 1'b1;
      @(negedge clk); go2 = 1'b0;
      while (!done2) @(negedge clk);
      @(negedge clk);
      chk(c2_tc - c2_cmp == 30 + MARG, "R7 period input wait", c2_tc - c2_cmp, 30 + MARG);
      chk(done2 && !fail2, "R7 period variant completes", int'(done2), 1);

      summary();
   end

endmodule